// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is the target end of a serial link on which a host controller sends fixed 16-bit words, one word per chip-select window. The serial clock, chip select and data line are brought into the system clock domain through two-flop synchronizers. Edges are then detected there, so the system clock must run at least four times faster than the serial clock. Bits are sampled on each rising serial-clock edge while chip select is low, most significant bit first.

When chip select is released after exactly sixteen bits, the block splits the word. The first four bits form an opcode and the remaining twelve bits form a payload. Both are presented with a one-cycle valid strobe and held until the next good word. A window of any other length is dropped and flagged with a one-cycle error pulse. One opcode is reserved for loading an internal 8-bit configuration register from the low byte of the payload.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, `cmd_valid` and `frame_error` are 0, and `cmd`, `data` and `cfg_word` are all zero.
- R2: Bits are sampled on rising `sck` while `csn` is low, MSB first. The first four bits become `cmd[3:0]`, with the first bit in `cmd[3]`. The next twelve bits become `data[11:0]`, with the fifth bit in `data[11]`.
- R3: When `csn` rises after exactly 16 sampled bits, `cmd_valid` is high for exactly one cycle and `frame_error` stays low.
- R4: When `csn` rises after any other number of bits (0, 1, 15 or 17 included), `frame_error` is high for exactly one cycle, `cmd_valid` stays low, and `cmd` and `data` keep their earlier values.
- R5: `cmd` and `data` change only in the cycle in which `cmd_valid` is high.
- R6: A valid word with opcode 4'h1 loads `data[7:0]` into `cfg_word`, in the same cycle as its `cmd_valid`. Any other opcode, and any rejected window, leaves `cfg_word` unchanged.
- R7: Toggling `sck` while `csn` is high produces no `cmd_valid` and no `frame_error`, and changes no output.
- R8: `cmd_valid` or `frame_error` goes high on the third rising `clk` edge after `csn` rises at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from host; idles low |
| csn | input | 1 | Active-low chip select from host |
| mosi | input | 1 | Serial data from host |
| cmd_valid | output | 1 | One-cycle strobe for an accepted word |
| cmd | output | 4 | Opcode of the last accepted word |
| data | output | 12 | Payload of the last accepted word |
| cfg_word | output | 8 | Configuration register |
| frame_error | output | 1 | One-cycle strobe for a rejected window |

## Verification
The valid strobe and the configuration-register load fall in the same cycle for the configuration opcode, so the two must stay aligned. The bench sends several configuration words, each with a different low byte, between words that carry other opcodes and windows of the wrong length. In each case it records the cycle in which `cmd_valid` is seen and checks `cfg_word` at that sample. It also checks that the other opcodes and the rejected windows leave `cfg_word` unchanged.

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
  parameter int CMD_W  = 4,
  parameter int DATA_W = 12,
  parameter int CFG_W  = 8,
  parameter int SYNC_N = 2,
  parameter logic [CMD_W-1:0] CFG_OP = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              mosi,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd,
  output logic [DATA_W-1:0] data,
  output logic [CFG_W-1:0]  cfg_word,
  output logic              frame_error
);
  localparam int WORD_W = CMD_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  logic [SYNC_N-1:0] sck_sy, csn_sy, mosi_sy;
  logic              sck_d, csn_d;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  wire sck_q   = sck_sy[SYNC_N-1];
  wire csn_q   = csn_sy[SYNC_N-1];
  wire mosi_q  = mosi_sy[SYNC_N-1];
  wire bit_stb = sck_q & ~sck_d & ~csn_q;
  wire cs_fall = ~csn_q & csn_d;
  wire cs_rise = csn_q & ~csn_d;
  wire [CMD_W-1:0] op_in = shreg[WORD_W-1 -: CMD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      csn_sy  <= '1;
      mosi_sy <= '0;
      sck_d   <= 1'b0;
      csn_d   <= 1'b1;
    end else begin
      sck_sy  <= {sck_sy[SYNC_N-2:0], sck};
      csn_sy  <= {csn_sy[SYNC_N-2:0], csn};
      mosi_sy <= {mosi_sy[SYNC_N-2:0], mosi};
      sck_d   <= sck_q;
      csn_d   <= csn_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
    end else if (bit_stb) begin
      shreg <= {shreg[WORD_W-2:0], mosi_q};
      if (cnt != OVER) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      frame_error <= 1'b0;
      cmd         <= '0;
      data        <= '0;
      cfg_word    <= '0;
    end else begin
      cmd_valid   <= cs_rise && cnt == FULL;
      frame_error <= cs_rise && cnt != FULL;
      if (cs_rise && cnt == FULL) begin
        cmd  <= op_in;
        data <= shreg[DATA_W-1:0];
        if (op_in == CFG_OP) cfg_word <= shreg[CFG_W-1:0];
      end
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r4_single_error: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |=> !frame_error);
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && frame_error));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> ($stable(cmd) && $stable(data)));
  a_r6_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CFG_OP) |-> cfg_word == data[CFG_W-1:0]);
  a_r6_cfg_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd == CFG_OP) |-> $stable(cfg_word));
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= OVER);
endmodule

// File: tb/spi_cmd_rx_tb.sv
module spi_cmd_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic cmd_valid, frame_error;
  logic [3:0] cmd;
  logic [11:0] data;
  logic [7:0] cfg_word;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_cmd_rx u_dut (.clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi),
    .cmd_valid(cmd_valid), .cmd(cmd), .data(data), .cfg_word(cfg_word),
    .frame_error(frame_error));

  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {5'd16, 16'h3ABC}, {5'd16, 16'h10F7}, {5'd15, 16'h2123}, {5'd17, 16'h4567},
    {5'd16, 16'hF000}, {5'd0,  16'h1234}, {5'd16, 16'h1E5A}, {5'd1,  16'h8000},
    {5'd16, 16'h0FFF}, {5'd16, 16'h1001}};

  logic [3:0] e_cmd = '0;
  logic [11:0] e_data = '0;
  logic [7:0] e_cfg = '0;
  int nv, ne, vk;
  logic [7:0] cfg_at_v;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input int nbits, input logic [15:0] w);
    csn = 1'b0;
    half();
    for (int b = 0; b < nbits; b++) begin
      mosi = (b < 16) ? w[15-b] : 1'b1;
      half();
      sck = 1'b1;
      half();
      sck = 1'b0;
    end
    half();
    csn = 1'b1;
    nv = 0; ne = 0; vk = 0; cfg_at_v = '0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (cmd_valid) begin nv++; vk = k; cfg_at_v = cfg_word; end
      if (frame_error) begin ne++; if (vk == 0) vk = k; end
    end
    half();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_valid == 0 && frame_error == 0, "R1 strobes", {cmd_valid, frame_error}, 0);
    chk(cmd == 0 && data == 0 && cfg_word == 0, "R1 regs", {cmd, data, cfg_word}, 0);
    rst_n = 1'b1;
    half();
    for (int i = 0; i < NV; i++) begin
      int nb;
      logic [15:0] w;
      bit ok;
      nb = int'(VEC[i][20:16]);
      w = VEC[i][15:0];
      ok = (nb == 16);
      send(nb, w);
      if (ok) begin
        e_cmd = w[15:12];
        e_data = w[11:0];
        if (w[15:12] == 4'h1) e_cfg = w[7:0];
        chk(nv == 1 && ne == 0, "R3 one valid pulse", nv * 16 + ne, 16);
        chk(cfg_at_v == e_cfg, "R6 cfg with strobe", cfg_at_v, e_cfg);
      end else begin
        chk(ne == 1 && nv == 0, "R4 one error pulse", ne * 16 + nv, 16);
      end
      chk(vk == 3, "R8 strobe latency", vk, 3);
      chk(cmd == e_cmd, "R2 cmd field", cmd, e_cmd);
      chk(data == e_data, "R2 R5 data field", data, e_data);
      chk(cfg_word == e_cfg, "R6 cfg value", cfg_word, e_cfg);
    end
    csn = 1'b1;
    for (int k = 0; k < 20; k++) begin
      mosi = k[0];
      sck = ~sck;
      half();
    end
    sck = 1'b0;
    nv = 0; ne = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (cmd_valid) nv++;
      if (frame_error) ne++;
    end
    chk(nv == 0 && ne == 0, "R7 no strobes", nv + ne, 0);
    chk(cmd == e_cmd && data == e_data && cfg_word == e_cfg, "R7 outputs kept",
        {cmd, data, cfg_word}, {e_cmd, e_data, e_cfg});
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule